// File: doc/BRIEF.md
# AXI memory traffic test sequencer

This block is a self-contained AXI4 master that exercises a memory slave and verifies it. A single start pulse launches a fixed five-phase test program. In every phase the block writes a set of bursts and then reads the same addresses back. Each returned beat is compared against a data pattern that is rebuilt from the beat's byte address, so no write data has to be stored inside the block.

Two burst lengths, A and B, are parameters and are set to suit the memory technology. The addresses either walk upward in steps of one burst or hop around under a 16-bit LFSR. At the end of the program the block raises `done`. The `pass` output tells whether any error was seen, and `err_count` gives the number of errors. Only one transaction is in flight at any time, and no IDs are used.

Top module: `axi_traffic_tester`

## Requirements
- R1: The program runs five phases in a fixed order: (1) one transaction at length A, (2) one transaction at length B, (3) a sequential block at length A, (4) a sequential block at length B, (5) a random block at length A. A block holds BLOCK_TXNS transactions. Within a phase, all writes are issued first and the reads follow in the same order. AWLEN and ARLEN carry the phase's length.
- R2: The sequential address restarts at 0 at the start of every write pass and every read pass. After each transaction it advances by (DATA_W/8)*(len+1) bytes.
- R3: The random address is 0 for the first transaction of a pass. After each transaction, a Galois LFSR steps: next = (s >> 1) XOR (s[0] ? 16'hB400 : 0), starting from seed 16'hACE1. The next address is that LFSR value shifted left by log2 of the larger burst size in bytes, then masked to the low RANGE_W bits. The read pass restarts from the seed and repeats the write pass's addresses.
- R4: Beat i of a transaction at address a uses the beat address a + i*(DATA_W/8). Its data is built from 16-bit lanes: lane k (bits 16k+15..16k) equals the low 16 bits of the beat address XOR (16'hC3A5 + k).
- R5: Each read beat whose RDATA differs from the R4 pattern adds one to the error count.
- R6: Each BRESP other than OKAY (2'b00) adds one to the error count. A read beat with an RRESP other than OKAY adds one to the error count. A read beat with both a bad response and bad data adds only one.
- R7: The error count saturates at 2^ERR_W-1 and never wraps.
- R8: At most one transaction is outstanding. A write finishes at its B handshake, and a read finishes at the handshake of the beat carrying RLAST. No new address is issued before the current transaction finishes.
- R9: Bursts use INCR (AxBURST = 2'b01). AxSIZE equals log2(DATA_W/8). All WSTRB bits are set. WLAST is high only on beat AxLEN.
- R10: After phase 5 completes, `done` goes high. `pass` equals done AND (err_count == 0). Both outputs hold until the next accepted start. Accepting a start clears `done` and `err_count` on the next cycle.
- R11: A start pulse that arrives while the program is running is ignored.
- R12: After reset, no valid is asserted, and `done`, `pass` and `err_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the program when idle or finished |
| done | output | 1 | Program finished |
| pass | output | 1 | Finished with no errors |
| err_count | output | ERR_W | Saturating error count |
| awaddr | output | ADDR_W | Write address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wlast | output | 1 | Final write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response |
| rlast | input | 1 | Final read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose.

- **Restart at a pass boundary.** If the address generator or the LFSR is not restarted when a pass begins, the random read pass probes addresses that were never written.
- **Sequential step size.** If the step is not tied to the current phase's burst length, the addresses in phase 4 drift away from those the bench predicts.
- **One increment per beat.** A read beat that carries both corrupted data and a bad RRESP must raise the count by exactly one, not two.
- **Counter saturation.** Corrupting every read beat pushes the count to its ceiling, where a wrapping counter would fall back to a small value.
- **Stray start.** A start pulse sent in the middle of the run must not restart the program, which would show up as extra transactions.
- **Output hold.** `done` and `pass` must stay put until the next start and then clear on the following cycle.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_AW,
      ST_W,
      ST_B,
      ST_AR,
      ST_R,
      ST_NEXT,
      ST_DONE
   } mt_state_e;

   localparam int unsigned NUM_PHASES = 5;
   localparam logic [15:0] PAT_BASE   = 16'hC3A5;
   localparam logic [15:0] LFSR_SEED  = 16'hACE1;
   localparam logic [15:0] LFSR_TAPS  = 16'hB400;
   localparam logic [1:0]  RESP_OKAY  = 2'b00;
   localparam logic [1:0]  BURST_INCR = 2'b01;

   function automatic logic [15:0] lfsr_step(input logic [15:0] s);
      return (s >> 1) ^ (s[0] ? LFSR_TAPS : 16'h0000);
   endfunction

endpackage

// File: rtl/mtest_pattern.sv
module mtest_pattern #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [15:0]       base_lo,
   input  logic [7:0]        beat,
   output logic [DATA_W-1:0] data
);
   import mtest_pkg::*;

   localparam int unsigned LANES = DATA_W / 16;
   localparam int unsigned BYTES = DATA_W / 8;

   logic [15:0] beat_lo;
   assign beat_lo = base_lo + (16'(beat) * 16'(BYTES));

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign data[k*16 +: 16] = beat_lo ^ (PAT_BASE + 16'(k));
   end

endmodule

// File: rtl/mtest_addr_gen.sv
module mtest_addr_gen #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned LEN_A   = 1,
   parameter int unsigned LEN_B   = 3,
   parameter int unsigned RANGE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic              rnd_mode,
   input  logic              use_b,
   output logic [ADDR_W-1:0] addr
);
   import mtest_pkg::*;

   localparam int unsigned BYTES     = DATA_W / 8;
   localparam int unsigned LMAX      = (LEN_A > LEN_B) ? LEN_A : LEN_B;
   localparam int unsigned RND_SHIFT = $clog2(BYTES * (LMAX + 1));
   localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(BYTES * (LEN_A + 1));
   localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(BYTES * (LEN_B + 1));
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'(1) << RND_SHIFT) - 1);

   logic [ADDR_W-1:0] range_mask;
   if (RANGE_W >= ADDR_W) begin : g_full_range
      assign range_mask = '1;
   end else begin : g_part_range
      assign range_mask = ADDR_W'((64'(1) << RANGE_W) - 1);
   end

   logic [ADDR_W-1:0] addr_q;
   logic [15:0]       lfsr_q;
   logic [15:0]       lfsr_nx;
   logic [ADDR_W-1:0] rnd_nx;
   logic [ADDR_W-1:0] seq_nx;

   assign lfsr_nx = lfsr_step(lfsr_q);
   assign rnd_nx  = (ADDR_W'(lfsr_nx) << RND_SHIFT) & range_mask;
   assign seq_nx  = addr_q + (use_b ? STEP_B : STEP_A);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         addr_q <= '0;
         lfsr_q <= LFSR_SEED;
      end else if (advance) begin
         if (rnd_mode) begin
            lfsr_q <= lfsr_nx;
            addr_q <= rnd_nx;
         end else begin
            addr_q <= seq_nx;
         end
      end
   end

   assign addr = addr_q;

   // R2: every pass begins at address zero
   assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (addr == '0));

   // R3: random hops stay burst-aligned and inside the range
   assert_rnd_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && rnd_mode && !restart) |=> (((addr & ALIGN_MASK) == '0) && ((addr & ~range_mask) == '0)));

endmodule

// File: rtl/mtest_err_ctr.sv
module mtest_err_ctr #(
   parameter int unsigned ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [ERR_W-1:0] count
);
   localparam logic [ERR_W-1:0] CNT_MAX = '1;

   logic [ERR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

   // R7: once at the ceiling the count stays there
   assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (count == CNT_MAX)) |=> (count == CNT_MAX));

   // R5: at most one step per cycle, never downward without a clear
   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

endmodule

// File: rtl/axi_traffic_tester.sv
module axi_traffic_tester #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned LEN_A      = 1,
   parameter int unsigned LEN_B      = 3,
   parameter int unsigned BLOCK_TXNS = 512,
   parameter int unsigned RANGE_W    = 20,
   parameter int unsigned ERR_W      = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                done,
   output logic                pass,
   output logic [ERR_W-1:0]    err_count,
   output logic [ADDR_W-1:0]   awaddr,
   output logic [7:0]          awlen,
   output logic [2:0]          awsize,
   output logic [1:0]          awburst,
   output logic                awvalid,
   input  logic                awready,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] wstrb,
   output logic                wlast,
   output logic                wvalid,
   input  logic                wready,
   input  logic [1:0]          bresp,
   input  logic                bvalid,
   output logic                bready,
   output logic [ADDR_W-1:0]   araddr,
   output logic [7:0]          arlen,
   output logic [2:0]          arsize,
   output logic [1:0]          arburst,
   output logic                arvalid,
   input  logic                arready,
   input  logic [DATA_W-1:0]   rdata,
   input  logic [1:0]          rresp,
   input  logic                rlast,
   input  logic                rvalid,
   output logic                rready
);
   import mtest_pkg::*;

   localparam int unsigned BYTES      = DATA_W / 8;
   localparam int unsigned SIZE_CODE  = $clog2(BYTES);
   localparam int unsigned TXN_W      = $clog2(BLOCK_TXNS + 1);
   localparam int unsigned LMAX       = (LEN_A > LEN_B) ? LEN_A : LEN_B;
   localparam int unsigned RND_SHIFT  = $clog2(BYTES * (LMAX + 1));
   localparam logic [2:0]  LAST_PHASE = 3'(NUM_PHASES - 1);

   // elaboration-time parameter checks
   if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_chk_data
      $error("DATA_W must be a non-zero multiple of 16");
   end
   if (ADDR_W < 16) begin : g_chk_addr
      $error("ADDR_W must be at least 16");
   end
   if (LEN_A > 255 || LEN_B > 255) begin : g_chk_len
      $error("burst lengths must fit an 8-bit length field");
   end
   if (((LMAX + 1) & LMAX) != 0) begin : g_chk_pow2
      $error("the larger burst must hold a power-of-two beat count");
   end
   if (BLOCK_TXNS < 1) begin : g_chk_block
      $error("BLOCK_TXNS must be at least 1");
   end
   if (RANGE_W <= RND_SHIFT || RANGE_W > ADDR_W) begin : g_chk_range
      $error("RANGE_W must exceed the burst alignment and fit ADDR_W");
   end

   mt_state_e         state;
   logic [2:0]        phase;
   logic              rd_pass;
   logic [TXN_W-1:0]  txn;
   logic [7:0]        beat;

   logic              use_b;
   logic              rnd_mode;
   logic              single;
   logic              last_txn;
   logic [7:0]        cur_len;
   logic              start_ok;
   logic              restart;
   logic              advance;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] exp_data;
   logic              err_inc;

   assign use_b    = (phase == 3'd1) || (phase == 3'd3);
   assign rnd_mode = (phase == 3'd4);
   assign single   = (phase < 3'd2);
   assign cur_len  = use_b ? 8'(LEN_B) : 8'(LEN_A);
   assign last_txn = single ? (txn == '0) : (txn == TXN_W'(BLOCK_TXNS - 1));
   assign start_ok = start && ((state == ST_IDLE) || (state == ST_DONE));
   assign restart  = start_ok || ((state == ST_NEXT) && last_txn);
   assign advance  = (state == ST_NEXT) && !last_txn;

   mtest_addr_gen #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .LEN_A   (LEN_A),
      .LEN_B   (LEN_B),
      .RANGE_W (RANGE_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .advance  (advance),
      .rnd_mode (rnd_mode),
      .use_b    (use_b),
      .addr     (cur_addr)
   );

   mtest_pattern #(
      .DATA_W (DATA_W)
   ) u_pat (
      .base_lo (cur_addr[15:0]),
      .beat    (beat),
      .data    (exp_data)
   );

   assign err_inc = ((state == ST_B) && bvalid && (bresp != RESP_OKAY)) ||
                    ((state == ST_R) && rvalid && ((rresp != RESP_OKAY) || (rdata != exp_data)));

   mtest_err_ctr #(
      .ERR_W (ERR_W)
   ) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .inc   (err_inc),
      .count (err_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         phase   <= '0;
         rd_pass <= 1'b0;
         txn     <= '0;
         beat    <= '0;
      end else if (start_ok) begin
         state   <= ST_AW;
         phase   <= '0;
         rd_pass <= 1'b0;
         txn     <= '0;
         beat    <= '0;
      end else begin
         unique case (state)
            ST_AW: if (awready) begin
               state <= ST_W;
               beat  <= '0;
            end
            ST_W: if (wready) begin
               if (beat == cur_len) state <= ST_B;
               else                 beat  <= beat + 8'd1;
            end
            ST_B: if (bvalid) state <= ST_NEXT;
            ST_AR: if (arready) begin
               state <= ST_R;
               beat  <= '0;
            end
            ST_R: if (rvalid) begin
               beat <= beat + 8'd1;
               if (rlast) state <= ST_NEXT;
            end
            ST_NEXT: begin
               if (last_txn) begin
                  txn <= '0;
                  if (!rd_pass) begin
                     rd_pass <= 1'b1;
                     state   <= ST_AR;
                  end else if (phase == LAST_PHASE) begin
                     state <= ST_DONE;
                  end else begin
                     phase   <= phase + 3'd1;
                     rd_pass <= 1'b0;
                     state   <= ST_AW;
                  end
               end else begin
                  txn   <= txn + 1'b1;
                  state <= rd_pass ? ST_AR : ST_AW;
               end
            end
            default: ;
         endcase
      end
   end

   assign awaddr  = cur_addr;
   assign araddr  = cur_addr;
   assign awlen   = cur_len;
   assign arlen   = cur_len;
   assign awsize  = 3'(SIZE_CODE);
   assign arsize  = 3'(SIZE_CODE);
   assign awburst = BURST_INCR;
   assign arburst = BURST_INCR;
   assign awvalid = (state == ST_AW);
   assign wvalid  = (state == ST_W);
   assign bready  = (state == ST_B);
   assign arvalid = (state == ST_AR);
   assign rready  = (state == ST_R);
   assign wdata   = exp_data;
   assign wstrb   = '1;
   assign wlast   = (beat == cur_len);
   assign done    = (state == ST_DONE);
   assign pass    = done && (err_count == '0);

   // R8: after the final write beat only the response is awaited
   assert_wait_bresp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid && wready && wlast && !start) |=> (bready && !awvalid && !arvalid));

   // R8: after the final read beat no channel is active for one cycle
   assert_read_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && rready && rlast && !start) |=> (!awvalid && !arvalid && !rready && !wvalid));

   // R9: address held stable while waiting for acceptance
   assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && !awready && !start) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

   // R10: completion outputs persist until a new start
   assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(err_count)));

   // R11: a start pulse mid-run does not abandon a pending read address
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && !arready) |=> (arvalid && $stable(araddr)));

endmodule

// File: tb/axi_traffic_tester_bench.sv
`timescale 1ns/1ps
module axi_traffic_tester_bench;

   localparam int unsigned ADDR_W     = 32;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned LEN_A      = 1;
   localparam int unsigned LEN_B      = 3;
   localparam int unsigned BLOCK_TXNS = 32;
   localparam int unsigned RANGE_W    = 16;
   localparam int unsigned ERR_W      = 4;
   localparam int unsigned BYTES      = DATA_W / 8;
   localparam int unsigned SHIFT      = 4;   // log2(4 bytes * 4 beats)
   localparam int unsigned ERR_MAX    = 15;
   localparam int unsigned RUN_CAP    = 40000;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic                done, pass;
   logic [ERR_W-1:0]    err_count;
   logic [ADDR_W-1:0]   awaddr, araddr;
   logic [7:0]          awlen, arlen;
   logic [2:0]          awsize, arsize;
   logic [1:0]          awburst, arburst;
   logic                awvalid, wvalid, arvalid, bready, rready, wlast;
   logic                awready = 1'b0, wready = 1'b0, arready = 1'b0;
   logic [DATA_W-1:0]   wdata;
   logic [DATA_W/8-1:0] wstrb;
   logic [1:0]          bresp = 2'b00, rresp = 2'b00;
   logic                bvalid = 1'b0, rvalid = 1'b0, rlast = 1'b0;
   logic [DATA_W-1:0]   rdata = '0;

   always #2 clk = ~clk;

   axi_traffic_tester #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LEN_A (LEN_A), .LEN_B (LEN_B),
      .BLOCK_TXNS (BLOCK_TXNS), .RANGE_W (RANGE_W), .ERR_W (ERR_W)
   ) u_axi_traffic_tester (
      .clk (clk), .rst_n (rst_n), .start (start), .done (done), .pass (pass),
      .err_count (err_count),
      .awaddr (awaddr), .awlen (awlen), .awsize (awsize), .awburst (awburst),
      .awvalid (awvalid), .awready (awready),
      .wdata (wdata), .wstrb (wstrb), .wlast (wlast), .wvalid (wvalid), .wready (wready),
      .bresp (bresp), .bvalid (bvalid), .bready (bready),
      .araddr (araddr), .arlen (arlen), .arsize (arsize), .arburst (arburst),
      .arvalid (arvalid), .arready (arready),
      .rdata (rdata), .rresp (rresp), .rlast (rlast), .rvalid (rvalid), .rready (rready)
   );

   int unsigned checks = 0;
   int unsigned errors = 0;

   // expected transaction list
   logic [31:0] exp_addr [$];
   logic [7:0]  exp_len  [$];
   bit          exp_wr   [$];
   bit          exp_rnd  [$];
   int unsigned idx;

   bit [31:0] mem [int unsigned];

   // slave and monitor state
   bit          inflight, b_pend, b_fire, r_active, r_fire;
   logic [31:0] w_addr, r_addr;
   logic [7:0]  w_len, w_beat, r_len, r_beat;
   int unsigned seq_addr_err, rnd_addr_err, order_err, data_err, attr_err, overlap_err, extra_txn;
   int unsigned injected, b_budget, r_budget;
   bit          corrupt_all;

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction

   function automatic logic [DATA_W-1:0] beat_pattern(input logic [31:0] ba);
      logic [DATA_W-1:0] d;
      for (int k = 0; k < DATA_W / 16; k++) d[k*16 +: 16] = ba[15:0] ^ (16'hC3A5 + 16'(k));
      return d;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic build_program();
      exp_addr.delete(); exp_len.delete(); exp_wr.delete(); exp_rnd.delete();
      for (int p = 0; p < 5; p++) begin
         int unsigned n   = (p < 2) ? 1 : BLOCK_TXNS;
         int unsigned len = (p == 1 || p == 3) ? LEN_B : LEN_A;
         bit          rnd = (p == 4);
         for (int ps = 0; ps < 2; ps++) begin
            logic [31:0] a = 32'h0;
            logic [15:0] s = 16'hACE1;
            for (int i = 0; i < int'(n); i++) begin
               exp_addr.push_back(a);
               exp_len.push_back(8'(len));
               exp_wr.push_back(ps == 0);
               exp_rnd.push_back(rnd);
               if (rnd) begin
                  s = lfsr_next(s);
                  a = ((32'(s)) << SHIFT) & 32'h0000FFFF;
               end else begin
                  a = a + 32'(BYTES * (len + 1));
               end
            end
         end
      end
   endtask

   task automatic note_request(input bit is_wr, input logic [31:0] a, input logic [7:0] len,
                               input logic [2:0] sz, input logic [1:0] bt);
      if (inflight) overlap_err++;
      if (sz != 3'd2 || bt != 2'b01) attr_err++;
      if (idx >= exp_addr.size()) begin
         extra_txn++;
      end else begin
         if (exp_wr[idx] != is_wr || exp_len[idx] != len) order_err++;
         if (exp_addr[idx] != a) begin
            if (exp_rnd[idx]) rnd_addr_err++;
            else              seq_addr_err++;
         end
      end
      idx++;
      inflight = 1'b1;
   endtask

   // memory slave, acting at negative edges
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            awready = 0; wready = 0; arready = 0; bvalid = 0; rvalid = 0; rlast = 0;
            inflight = 0; b_pend = 0; b_fire = 0; r_active = 0; r_fire = 0;
            continue;
         end
         if (b_fire) begin
            bvalid = 0; b_fire = 0; inflight = 0;
         end
         if (r_fire) begin
            r_fire = 0; rvalid = 0;
            if (r_beat == r_len) begin
               r_active = 0; inflight = 0;
            end else begin
               r_beat = r_beat + 8'd1;
            end
         end
         awready = ($urandom % 4) != 0;
         wready  = ($urandom % 4) != 0;
         arready = ($urandom % 4) != 0;
         if (b_pend && !bvalid && ($urandom % 3) != 0) begin
            bvalid = 1; b_pend = 0; bresp = 2'b00;
            if (b_budget > 0 && ($urandom % 6) == 0) begin
               bresp = 2'b10; b_budget--; injected++;
            end
         end
         if (r_active && !rvalid && ($urandom % 3) != 0) begin
            logic [31:0] ba;
            ba     = r_addr + 32'(r_beat) * BYTES;
            rvalid = 1;
            rdata  = mem.exists(ba) ? mem[ba] : '0;
            rresp  = 2'b00;
            rlast  = (r_beat == r_len);
            if (corrupt_all) begin
               rdata = rdata ^ 32'h1; injected++;
            end else if (r_budget > 0 && ($urandom % 20) == 0) begin
               int unsigned kind = $urandom % 3;
               if (kind != 1) rdata = rdata ^ 32'h0100;
               if (kind != 0) rresp = 2'b10;
               r_budget--; injected++;
            end
         end
         if (awvalid && awready) begin
            note_request(1'b1, awaddr, awlen, awsize, awburst);
            w_addr = awaddr; w_len = awlen; w_beat = 0;
         end
         if (wvalid && wready) begin
            logic [31:0] ba;
            ba = w_addr + 32'(w_beat) * BYTES;
            if (wdata != beat_pattern(ba)) data_err++;
            if (wstrb != '1 || wlast != (w_beat == w_len)) attr_err++;
            mem[ba] = wdata;
            if (wlast) b_pend = 1;
            w_beat = w_beat + 8'd1;
         end
         if (arvalid && arready) begin
            note_request(1'b0, araddr, arlen, arsize, arburst);
            r_addr = araddr; r_len = arlen; r_beat = 0; r_active = 1;
         end
         if (bvalid && bready) b_fire = 1;
         if (rvalid && rready) r_fire = 1;
      end
   end

   bit aborted = 0;

   task automatic run_program(input int unsigned bb, input int unsigned rb, input bit all_bad,
                              input bit stray_start, input string tag);
      int unsigned cyc = 0;
      int unsigned exp_err;
      idx = 0; seq_addr_err = 0; rnd_addr_err = 0; order_err = 0; data_err = 0;
      attr_err = 0; overlap_err = 0; extra_txn = 0; injected = 0;
      b_budget = bb; r_budget = rb; corrupt_all = all_bad;
      build_program();
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      check(done == 1'b0 && err_count == '0, "R10", "done/err cleared after start",
            {done, err_count}, 0);
      while (!done && cyc < RUN_CAP) begin
         @(negedge clk);
         cyc++;
         if (stray_start && cyc == 300) start = 1;
         if (stray_start && cyc == 301) start = 0;
      end
      if (!done) begin
         check(0, "R10", {"watchdog expired in ", tag}, cyc, RUN_CAP);
         aborted = 1;
         return;
      end
      exp_err = (injected > ERR_MAX) ? ERR_MAX : injected;
      check(idx == exp_addr.size() && extra_txn == 0 && order_err == 0, stray_start ? "R11" : "R1",
            {"transaction count and order ", tag}, idx, exp_addr.size());
      check(seq_addr_err == 0, "R2", {"sequential addresses ", tag}, seq_addr_err, 0);
      check(rnd_addr_err == 0, "R3", {"random addresses ", tag}, rnd_addr_err, 0);
      check(data_err == 0, "R4", {"write data pattern ", tag}, data_err, 0);
      check(attr_err == 0, "R9", {"burst attributes ", tag}, attr_err, 0);
      check(overlap_err == 0, "R8", {"single outstanding ", tag}, overlap_err, 0);
      check(err_count == ERR_W'(exp_err), all_bad ? "R7" : ((bb > 0) ? "R6" : "R5"),
            {"error count ", tag}, err_count, exp_err);
      check(pass == (exp_err == 0), "R10", {"pass flag ", tag}, pass, exp_err == 0);
   endtask

   initial begin
      logic             h_pass;
      logic [ERR_W-1:0] h_err;
      void'($urandom(32'h5EED1234));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12: quiet outputs after reset
      check(!awvalid && !wvalid && !arvalid, "R12", "no valid after reset",
            {awvalid, wvalid, arvalid}, 0);
      check(!done && !pass && err_count == '0, "R12", "status zero after reset",
            {done, pass, err_count}, 0);

      run_program(0, 0, 0, 0, "clean");
      if (!aborted) begin
         h_pass = pass; h_err = err_count;
         repeat (12) @(negedge clk);
         check(done && pass == h_pass && err_count == h_err, "R10", "outputs hold after done",
               {done, pass, err_count}, {1'b1, h_pass, h_err});
      end
      if (!aborted) run_program(0, 6, 0, 0, "read faults");
      if (!aborted) run_program(4, 0, 0, 0, "write faults");
      if (!aborted) run_program(3, 5, 0, 0, "mixed faults");
      if (!aborted) run_program(0, 0, 1, 0, "saturation");
      if (!aborted) run_program(0, 0, 0, 1, "stray start");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule